// File: doc/BRIEF.md
# UART-Timed 1-Wire Bus Master

This block drives a single open-drain 1-Wire line using the timing of a UART frame. Every bus operation is one ten-bit frame: a low start bit, eight data bits sent least significant bit first, and a high stop bit. The block picks one pattern byte and one of two bit rates for each operation. Where the pattern is 0 the line is pulled low. Where it is 1 the line is released. Transmit and receive run together, so the block samples its own frame back off the wire. A slave that holds the line low during a released bit changes the echoed byte. The block turns that difference into a presence flag or a read-bit value.

A host issues one command at a time: a bus reset with presence detect, a write of one bit, or a read of one bit. The host waits for the one-cycle done strobe and then reads the presence flag or the read value, each of which is held until the next operation of its kind. Bit rates come from parameters and the system clock frequency. Each bit period is sixteen oversampling ticks, and each echo bit is sampled at the middle tick.

Top module: `uart_wire_master`

## Requirements
- R1: After reset, busy, lineOe, doneStb, presence and readBit are all 0.
- R2: A command with cmdOp = 0 (bus reset) runs at the slow rate and sends pattern 0xF0 after the start bit. lineOe is therefore high for 5 slow bit times, i.e. 80*SLOW_DIV cycles.
- R3: At the end of a reset frame, presence becomes 1 when the echoed data byte differs from 0xF0, and 0 when it equals 0xF0.
- R4: A command with cmdOp = 1 and cmdBit = 0 (write 0) runs at the fast rate and sends 0x80. lineOe is high for 8 fast bit times, i.e. 128*FAST_DIV cycles.
- R5: A write with cmdBit = 1, and any command with cmdOp = 2 (read), runs at the fast rate and sends 0xFF. lineOe is high for the start bit only, i.e. 16*FAST_DIV cycles.
- R6: At the end of a read frame, readBit becomes 1 when the echoed byte is 0xFF, and 0 otherwise.
- R7: doneStb is high for exactly one cycle, 160*DIV+1 cycles after the edge that accepts the command (DIV is the divider of the frame's rate). presence and readBit change only together with doneStb and are held otherwise.
- R8: A command offered while busy is 1 has no effect, and so does cmdOp = 3. It starts no frame, does not alter the running frame's timing, and changes no result.
- R9: lineOe is 0 whenever busy is 0, and the bit rate does not change while a frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, taken only while busy is 0 |
| cmdOp | input | 2 | 0 bus reset, 1 write bit, 2 read bit, 3 no operation |
| cmdBit | input | 1 | Value for a write command |
| busy | output | 1 | A frame is in progress |
| doneStb | output | 1 | One-cycle strobe: the operation finished and results are valid |
| presence | output | 1 | A slave answered the last bus reset |
| readBit | output | 1 | Value of the last read slot |
| lineOe | output | 1 | Drive the bus low when 1; release it when 0 |
| lineIn | input | 1 | Sampled level of the bus |

## Verification
Every result is due a fixed number of cycles after the accepting edge: 160*DIV+1 cycles for doneStb, with presence and readBit valid in that same cycle. The low phase of lineOe lasts an exact multiple of 16*DIV cycles, counted from that edge. Each scenario task drives the command just after a falling clock edge. It then counts rising edges from the accepting one and samples on the falling edges. The elapsed count at doneStb and the number of falling edges with lineOe high are compared against those exact figures. A slave model pulls the wire low for a set number of cycles after each falling edge of the wire, which produces known echo bytes for the presence and read-value checks.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } opcode_e;

  // strobes and frame setup handed from control to datapath
  typedef struct packed {
    logic       start;
    logic       fast;
    logic [7:0] txByte;
  } dp_ctrl_s;

  localparam logic [7:0] PAT_RESET  = 8'hF0;
  localparam logic [7:0] PAT_ZERO   = 8'h80;
  localparam logic [7:0] PAT_SHORT  = 8'hFF;

endpackage

// File: rtl/uwm_datapath.sv
module uwm_datapath
  import uwm_pkg::*;
#(
  parameter int SLOW_DIV = 325,
  parameter int FAST_DIV = 27,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_ctrl_s   dpCtrl,
  input  logic       lineIn,
  output logic       lineOe,
  output logic       frameDone,
  output logic [7:0] rxByte,
  output logic       rateFast
);
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int MAX_DIV    = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DIV_W      = $clog2(MAX_DIV) + 1;
  localparam int SUB_W      = $clog2(OVS);
  localparam int IDX_W      = $clog2(FRAME_BITS);

  logic                  active;
  logic                  fastSel;
  logic [DIV_W-1:0]      divCnt;
  logic [SUB_W-1:0]      subCnt;
  logic [IDX_W-1:0]      bitIdx;
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_BITS-1:0]  rxShift;
  logic [1:0]            syncQ;
  logic                  divLast;
  logic                  tick;
  logic                  midTick;
  logic                  endTick;
  logic                  dataBit;

  assign divLast = fastSel ? (divCnt == DIV_W'(FAST_DIV - 1))
                           : (divCnt == DIV_W'(SLOW_DIV - 1));
  assign tick    = active && divLast;
  assign midTick = tick && (subCnt == SUB_W'(OVS / 2 - 1));
  assign endTick = tick && (subCnt == SUB_W'(OVS - 1));
  assign dataBit = (bitIdx != '0) && (bitIdx != IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      fastSel   <= 1'b0;
      divCnt    <= '0;
      subCnt    <= '0;
      bitIdx    <= '0;
      txShift   <= '1;
      rxShift   <= '0;
      syncQ     <= 2'b11;
      frameDone <= 1'b0;
    end else begin
      syncQ     <= {syncQ[0], lineIn};
      frameDone <= 1'b0;
      if (dpCtrl.start && !active) begin
        active  <= 1'b1;
        fastSel <= dpCtrl.fast;
        divCnt  <= '0;
        subCnt  <= '0;
        bitIdx  <= '0;
        txShift <= {1'b1, dpCtrl.txByte, 1'b0};
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          subCnt <= subCnt + 1'b1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        if (midTick && dataBit) begin
          rxShift <= {syncQ[1], rxShift[DATA_BITS-1:1]};
        end
        if (endTick) begin
          txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
          bitIdx  <= bitIdx + 1'b1;
          if (bitIdx == IDX_W'(FRAME_BITS - 1)) begin
            active    <= 1'b0;
            frameDone <= 1'b1;
          end
        end
      end
    end
  end

  assign lineOe   = active && !txShift[0];
  assign rxByte   = rxShift;
  assign rateFast = fastSel;

endmodule

// File: rtl/uwm_ctrl.sv
module uwm_ctrl
  import uwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       frameDone,
  input  logic [7:0] rxByte,
  output dp_ctrl_s   dpCtrl,
  output logic       busy,
  output logic       doneStb,
  output logic       presence,
  output logic       readBit
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e  state;
  opcode_e curOp;
  opcode_e newOp;
  logic    accept;

  assign newOp  = opcode_e'(cmdOp);
  assign accept = (state == ST_IDLE) && cmdValid && (newOp != OP_NONE);

  always_comb begin
    dpCtrl.start = accept;
    dpCtrl.fast  = (newOp != OP_RESET);
    if (newOp == OP_RESET)
      dpCtrl.txByte = PAT_RESET;
    else if ((newOp == OP_WRITE) && !cmdBit)
      dpCtrl.txByte = PAT_ZERO;
    else
      dpCtrl.txByte = PAT_SHORT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curOp    <= OP_NONE;
      doneStb  <= 1'b0;
      presence <= 1'b0;
      readBit  <= 1'b0;
    end else begin
      doneStb <= 1'b0;
      if (accept) begin
        state <= ST_RUN;
        curOp <= newOp;
      end else if ((state == ST_RUN) && frameDone) begin
        state   <= ST_IDLE;
        doneStb <= 1'b1;
        if (curOp == OP_RESET) presence <= (rxByte != PAT_RESET);
        if (curOp == OP_READ)  readBit  <= (rxByte == PAT_SHORT);
      end
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/uart_wire_master.sv
module uart_wire_master
  import uwm_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SLOW_BAUD = 9600,
  parameter int FAST_BAUD = 115200,
  parameter int OVS       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  output logic       busy,
  output logic       doneStb,
  output logic       presence,
  output logic       readBit,
  output logic       lineOe,
  input  logic       lineIn
);
  localparam int SLOW_DIV = (CLK_HZ + SLOW_BAUD * OVS / 2) / (SLOW_BAUD * OVS);
  localparam int FAST_DIV = (CLK_HZ + FAST_BAUD * OVS / 2) / (FAST_BAUD * OVS);

  dp_ctrl_s   dpCtrl;
  logic       frameDone;
  logic [7:0] rxByte;
  logic       rateFast;

  uwm_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdBit   (cmdBit),
    .frameDone(frameDone),
    .rxByte   (rxByte),
    .dpCtrl   (dpCtrl),
    .busy     (busy),
    .doneStb  (doneStb),
    .presence (presence),
    .readBit  (readBit)
  );

  uwm_datapath #(
    .SLOW_DIV(SLOW_DIV),
    .FAST_DIV(FAST_DIV),
    .OVS     (OVS)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .lineIn   (lineIn),
    .lineOe   (lineOe),
    .frameDone(frameDone),
    .rxByte   (rxByte),
    .rateFast (rateFast)
  );

endmodule

// File: rtl/uwm_checker.sv
module uwm_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] cmdOp,
  input logic       busy,
  input logic       doneStb,
  input logic       presence,
  input logic       readBit,
  input logic       lineOe,
  input logic       rateFast
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOe); // R9
  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rateFast)); // R9
  AST_RESET_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (rateFast == ($past(cmdOp) != 2'd0))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (!busy && $past(busy))); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !doneStb |-> ($stable(presence) && $stable(readBit))); // R7
endmodule

bind uart_wire_master uwm_checker i_uwm_checker (
  .clk     (clk),
  .rstN    (rstN),
  .cmdOp   (cmdOp),
  .busy    (busy),
  .doneStb (doneStb),
  .presence(presence),
  .readBit (readBit),
  .lineOe  (lineOe),
  .rateFast(rateFast)
);

// File: tb/test_uart_wire_master.sv
module test_uart_wire_master;
  localparam int CLK_HZ    = 50_000_000;
  localparam int SLOW_BAUD = 96_000;
  localparam int FAST_BAUD = 1_152_000;
  localparam int OVS       = 16;
  localparam int SLOW_DIV  = (CLK_HZ + SLOW_BAUD * OVS / 2) / (SLOW_BAUD * OVS);
  localparam int FAST_DIV  = (CLK_HZ + FAST_BAUD * OVS / 2) / (FAST_BAUD * OVS);
  localparam int SBIT      = OVS * SLOW_DIV;
  localparam int FBIT      = OVS * FAST_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd3;
  logic       cmdBit = 1'b0;
  logic       busy, doneStb, presence, readBit, lineOe, lineIn;

  logic       slaveEn = 1'b0;
  int         slaveLen = 0;
  int         pullCnt = 0;
  logic       wirePrev = 1'b1;
  logic       slavePull;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  assign slavePull = (pullCnt != 0);
  assign lineIn    = ~(lineOe | slavePull);

  // slave: pulls low for slaveLen cycles after each falling edge of the wire
  always @(posedge clk) begin
    wirePrev <= lineIn;
    if (slaveEn && wirePrev && !lineIn && pullCnt == 0) pullCnt <= slaveLen;
    else if (pullCnt != 0) pullCnt <= pullCnt - 1;
  end

  uart_wire_master #(
    .CLK_HZ(CLK_HZ), .SLOW_BAUD(SLOW_BAUD), .FAST_BAUD(FAST_BAUD), .OVS(OVS)
  ) i_uart_wire_master (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBit(cmdBit),
    .busy(busy), .doneStb(doneStb), .presence(presence), .readBit(readBit),
    .lineOe(lineOe), .lineIn(lineIn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one command, measures lineOe low-drive cycles and done latency
  task automatic runOp(input logic [1:0] op, input logic b, input bit intrude,
                       output int lowCnt, output int lat);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdBit = b;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd3;
    lowCnt = lineOe ? 1 : 0;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (doneStb || lat > 12 * SBIT) break;
      lowCnt += lineOe ? 1 : 0;
      if (intrude && lat == 100) begin
        cmdValid = 1'b1; cmdOp = 2'd0;
      end else begin
        cmdValid = 1'b0; cmdOp = 2'd3;
      end
    end
    cmdValid = 1'b0;
  endtask

  task automatic testAfterReset();
    chk(!busy && !lineOe && !doneStb, "R1 idle outputs", {busy, lineOe, doneStb}, 0);
    chk(!presence && !readBit, "R1 results", {presence, readBit}, 0);
  endtask

  task automatic testBusReset(input bit slave, input bit expPres);
    int lowCnt, lat;
    slaveEn = slave; slaveLen = 3500;
    runOp(2'd0, 1'b0, 1'b0, lowCnt, lat);
    chk(lowCnt == 5 * SBIT, "R2 reset low time", lowCnt, 5 * SBIT);
    chk(lat == 10 * SBIT + 1, "R7 reset done latency", lat, 10 * SBIT + 1);
    chk(presence == expPres, "R3 presence", presence, expPres);
    chk(!busy && !lineOe, "R9 released after frame", {busy, lineOe}, 0);
    slaveEn = 1'b0;
    @(negedge clk);
    chk(!doneStb, "R7 done single cycle", doneStb, 0);
  endtask

  task automatic testWrite(input logic b);
    int lowCnt, lat, expLow;
    expLow = b ? FBIT : 8 * FBIT;
    runOp(2'd1, b, 1'b0, lowCnt, lat);
    if (b) chk(lowCnt == expLow, "R5 write1 low time", lowCnt, expLow);
    else   chk(lowCnt == expLow, "R4 write0 low time", lowCnt, expLow);
    chk(lat == 10 * FBIT + 1, "R7 write done latency", lat, 10 * FBIT + 1);
  endtask

  task automatic testRead(input bit slave, input bit expBit, input bit intrude);
    int lowCnt, lat;
    bit presBefore;
    presBefore = presence;
    slaveEn = slave; slaveLen = 200;
    runOp(2'd2, 1'b0, intrude, lowCnt, lat);
    chk(lowCnt == FBIT, "R5 read low time", lowCnt, FBIT);
    chk(readBit == expBit, "R6 read value", readBit, expBit);
    chk(lat == 10 * FBIT + 1, "R7 read done latency", lat, 10 * FBIT + 1);
    chk(presence == presBefore, "R7 presence held over read", presence, presBefore);
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk(!busy && !lineOe, "R8 busy-time command ignored", {busy, lineOe}, 0);
    end
    slaveEn = 1'b0;
  endtask

  task automatic testNoOp();
    bit sawActivity;
    bit pBefore, rBefore;
    sawActivity = 1'b0;
    pBefore = presence; rBefore = readBit;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'd3;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || lineOe || doneStb) sawActivity = 1'b1;
    end
    cmdValid = 1'b0;
    chk(!sawActivity, "R8 opcode 3 ignored", sawActivity, 0);
    chk(presence == pBefore && readBit == rBefore, "R8 results unchanged",
        {presence, readBit}, {pBefore, rBefore});
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testAfterReset();
    testBusReset(1'b0, 1'b0);
    testBusReset(1'b1, 1'b1);
    testWrite(1'b0);
    testWrite(1'b1);
    testRead(1'b1, 1'b0, 1'b0);
    testRead(1'b0, 1'b1, 1'b0);
    testRead(1'b1, 1'b0, 1'b1);
    testNoOp();
    testBusReset(1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150_000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule